// File: doc/BRIEF.md
# Programmable-Resolution Successive-Approximation Sequencer

This block is the digital controller of a charge-redistribution converter. A one-bit comparator input stands in for the analog comparator. The block drives the capacitor-array switch word and returns a right-justified result code. A start request is qualified by an internal clock that runs at half the input clock rate. When acquisition begins, the track output is raised for three periods of that divided clock. The block then makes one bit decision per divided-clock period and raises a one-cycle done strobe together with the new result.

Each start request carries its own configuration: 8 or 10 magnitude bits, unsigned or signed. A signed conversion adds one decision at the top of the word, before the magnitude bits. The conversion length therefore ranges from 8 to 11 decisions. An unsigned conversion of a negative differential input resolves to zero. A signed conversion returns an 11-bit two's-complement code, sign-extended in the 8-bit case. A start that arrives while a conversion is running is held and taken up once that conversion finishes.

Top module: `sarSequencer`

## Requirements
- R1: While rstN is low, and right after it, the divider phase, trackEn, done, dacWord and result are all zero.
- R2: A start pulse sampled at a clock edge raises trackEn one or two clocks later, on the first divided-clock falling edge that sees the held request. trackEn then stays high for exactly 6 clocks, and no bit decision is made while it is high.
- R3: After trackEn falls, done rises exactly 2N clocks later, where N is 8 (unsigned 8-bit), 9 (signed 8-bit), 10 (unsigned 10-bit) or 11 (signed 10-bit).
- R4: done is high for one clock only, and it rises only on a falling edge of the divided clock: the divider phase reads 0 while done is high.
- R5: dacWord bit 10 is the sign (offset) switch and bits 9..0 are the binary-weighted magnitude switches; 8-bit modes use bits 9..2 only. Decisions run from the top bit down. Each trial bit is set at the start of its period and kept when compHi is 1 at the end of that period, otherwise cleared. compHi = 1 means the input is at or above the level the switch word represents.
- R6: An unsigned result is the magnitude, zero-extended. An input below zero gives 0, and dacWord bit 10 stays 0 throughout an unsigned conversion.
- R7: A signed result is two's complement over 11 bits. In 10-bit mode, a full-scale positive input gives 0x3FF, an input of one step gives 0x001, an input of minus one step gives 0x7FF, and negative full scale gives 0x400.
- R8: In 8-bit modes the result equals floor(input/4), the input being expressed in 10-bit steps; a signed result is sign-extended to 11 bits.
- R9: A start pulse received during a conversion is held, with its own configuration, and launches a new acquisition after done. It does not change the result of the conversion already running.
- R10: result changes only at the edge that raises done, and holds its value between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; decisions use half this rate |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-clock start request |
| cfgWide | input | 1 | 1 = 10 magnitude bits, 0 = 8, captured with startReq |
| cfgSigned | input | 1 | 1 = signed conversion with sign decision, captured with startReq |
| compHi | input | 1 | Comparator: input at or above the DAC level |
| trackEn | output | 1 | High during acquisition (input switches tracking) |
| dacWord | output | 11 | Capacitor-array switch word, offset binary in signed mode |
| done | output | 1 | One-clock pulse when a result is ready |
| result | output | 11 | Right-justified result code |

## Verification
On every cycle the assertions check four things: done lasts one clock and falls on the divided-clock phase, no decision is made during tracking, a held request survives until launch, and the sign switch stays open in unsigned mode. They also check that the result moves only on a final decision and that control never asks for a decision with no trial bit pending. Only the bench's scenarios can show the numeric outcome of a conversion. That covers the clamp of negative inputs in unsigned mode, the two's-complement codes at both full scales and at one step, and the floor behaviour of the 8-bit modes. The scenarios also measure the exact clock counts of tracking and of each of the four conversion lengths, and confirm that a queued request runs with the configuration that came with it.

// File: rtl/sarSeqPkg.sv
package sarSeqPkg;

  typedef struct packed {
    logic wide;      // 10 magnitude bits when set, else 8
    logic isSigned;  // extra sign decision first
  } convCfg_t;

  typedef struct packed {
    logic load;    // place first trial bit
    logic decide;  // resolve current trial bit
    logic last;    // current decision is the final one
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2
  } seqState_t;

endpackage

// File: rtl/sarSeqCtrl.sv
module sarSeqCtrl
  import sarSeqPkg::*;
#(
  parameter int MAG_WIDE   = 10,
  parameter int MAG_NARROW = 8,
  parameter int ACQ_TICKS  = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  convCfg_t  reqCfg,
  output dpStrobe_t strb,
  output convCfg_t  activeCfg,
  output logic      trackEn,
  output logic      done
);

  localparam int CNT_W = $clog2(MAG_WIDE + ACQ_TICKS + 2);

  logic             half;
  logic             pendValid;
  convCfg_t         pendCfg;
  convCfg_t         curCfg;
  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nBits;
  logic             tick;
  logic             launch;
  logic             acqEnd;

  // a divided-clock falling edge happens at every clk edge where half is 1
  assign tick = half;

  always_comb begin
    nBits = curCfg.wide ? CNT_W'(MAG_WIDE) : CNT_W'(MAG_NARROW);
    if (curCfg.isSigned) nBits = nBits + CNT_W'(1);
  end

  assign launch      = tick && (state == ST_IDLE) && pendValid;
  assign acqEnd      = tick && (state == ST_ACQ) && (cnt == CNT_W'(ACQ_TICKS - 1));
  assign strb.load   = acqEnd;
  assign strb.decide = tick && (state == ST_CONV);
  assign strb.last   = (cnt == nBits - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      half      <= 1'b0;
      pendValid <= 1'b0;
      pendCfg   <= '0;
      curCfg    <= '0;
      state     <= ST_IDLE;
      cnt       <= '0;
      done      <= 1'b0;
    end else begin
      half <= ~half;
      done <= strb.decide && strb.last;

      if (startReq) begin
        pendValid <= 1'b1;
        pendCfg   <= reqCfg;
      end else if (launch) begin
        pendValid <= 1'b0;
      end

      case (state)
        ST_IDLE: begin
          if (launch) begin
            state  <= ST_ACQ;
            curCfg <= pendCfg;
            cnt    <= '0;
          end
        end
        ST_ACQ: begin
          if (acqEnd) begin
            state <= ST_CONV;
            cnt   <= '0;
          end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_CONV: begin
          if (strb.decide) begin
            if (strb.last) state <= ST_IDLE;
            else           cnt   <= cnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign trackEn   = (state == ST_ACQ);
  assign activeCfg = curCfg;

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4
  done_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !half);

  // R2
  no_decide_in_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    trackEn |-> !strb.decide);

  // R9
  pend_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && state != ST_IDLE) |=> pendValid);

endmodule

// File: rtl/sarSeqData.sv
module sarSeqData
  import sarSeqPkg::*;
#(
  parameter int MAG_WIDE   = 10,
  parameter int MAG_NARROW = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strb,
  input  convCfg_t            cfg,
  input  logic                compHi,
  output logic [MAG_WIDE:0]   dacWord,
  output logic [MAG_WIDE:0]   result
);

  localparam int W         = MAG_WIDE + 1;
  localparam int NARROW_LO = MAG_WIDE - MAG_NARROW;
  localparam int FILL      = W - MAG_NARROW;

  logic [W-1:0]          word;
  logic [W-1:0]          mask;
  logic [W-1:0]          firstMask;
  logic [W-1:0]          resolved;
  logic [W-1:0]          fmt;
  logic                  signBit;
  logic [MAG_NARROW-1:0] narrowMag;

  assign firstMask = cfg.isSigned ? (W'(1) << (W - 1)) : (W'(1) << (W - 2));
  assign resolved  = compHi ? word : (word & ~mask);
  assign signBit   = ~resolved[W-1];
  assign narrowMag = resolved[W-2:NARROW_LO];

  always_comb begin
    case ({cfg.wide, cfg.isSigned})
      2'b11:   fmt = {signBit, resolved[W-2:0]};
      2'b10:   fmt = {1'b0, resolved[W-2:0]};
      2'b01:   fmt = {{FILL{signBit}}, narrowMag};
      default: fmt = {{FILL{1'b0}}, narrowMag};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      word   <= '0;
      mask   <= '0;
      result <= '0;
    end else if (strb.load) begin
      word <= firstMask;
      mask <= firstMask;
    end else if (strb.decide) begin
      if (strb.last) begin
        word   <= resolved;
        mask   <= '0;
        result <= fmt;
      end else begin
        word <= resolved | (mask >> 1);
        mask <= mask >> 1;
      end
    end
  end

  assign dacWord = word;

  // R6
  unsigned_sign_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mask != '0 && !cfg.isSigned) |-> !word[W-1]);

  // R5
  decide_has_trial_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.decide |-> (mask != '0));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.decide && strb.last) |=> $stable(result));

endmodule

// File: rtl/sarSequencer.sv
module sarSequencer
  import sarSeqPkg::*;
#(
  parameter int MAG_WIDE   = 10,
  parameter int MAG_NARROW = 8,
  parameter int ACQ_TICKS  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              cfgWide,
  input  logic              cfgSigned,
  input  logic              compHi,
  output logic              trackEn,
  output logic [MAG_WIDE:0] dacWord,
  output logic              done,
  output logic [MAG_WIDE:0] result
);

  convCfg_t  reqCfg;
  convCfg_t  activeCfg;
  dpStrobe_t strb;

  assign reqCfg.wide     = cfgWide;
  assign reqCfg.isSigned = cfgSigned;

  sarSeqCtrl #(
    .MAG_WIDE  (MAG_WIDE),
    .MAG_NARROW(MAG_NARROW),
    .ACQ_TICKS (ACQ_TICKS)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .reqCfg   (reqCfg),
    .strb     (strb),
    .activeCfg(activeCfg),
    .trackEn  (trackEn),
    .done     (done)
  );

  sarSeqData #(
    .MAG_WIDE  (MAG_WIDE),
    .MAG_NARROW(MAG_NARROW)
  ) data_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .cfg    (activeCfg),
    .compHi (compHi),
    .dacWord(dacWord),
    .result (result)
  );

endmodule

// File: tb/sarSequencer_tb.sv
module sarSequencer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        cfgWide = 1'b0;
  logic        cfgSigned = 1'b0;
  logic        compHi;
  logic        trackEn;
  logic [10:0] dacWord;
  logic        done;
  logic [10:0] result;

  int tests = 0;
  int fails = 0;
  int vin = 0;
  bit tbSigned = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sarSequencer dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cfgWide(cfgWide),
    .cfgSigned(cfgSigned), .compHi(compHi), .trackEn(trackEn),
    .dacWord(dacWord), .done(done), .result(result)
  );

  // comparator model: level in 10-bit steps, offset binary when signed
  always_comb begin
    int lvl;
    lvl = tbSigned ? (int'(dacWord) - 1024) : int'(dacWord);
    compHi = (vin >= lvl);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampI(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic int expCode(input bit wide, input bit sgn, input int x);
    int v;
    if (sgn) v = wide ? clampI(x, -1024, 1023) : clampI(x >>> 2, -256, 255);
    else begin
      v = clampI(x, 0, 1023);
      if (!wide) v = v >> 2;
    end
    return v & 32'h7FF;
  endfunction

  task automatic pulseStart(input bit wide, input bit sgn);
    @(negedge clk);
    cfgWide = wide; cfgSigned = sgn; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  // R1
  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(done == 0 && trackEn == 0, "R1 done/track in reset", int'({done, trackEn}), 0);
    chk(result == 0 && dacWord == 0, "R1 result/dac in reset", int'(result | dacWord), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(result == 0 && done == 0, "R1 state after release", int'(result), 0);
  endtask

  // R2 R3 R5 R6 R7 R8 R10
  task automatic runOne(input bit wide, input bit sgn, input int x);
    int lat, hi, conv, n;
    bit sawTop;
    tbSigned = sgn; vin = x;
    n = (wide ? 10 : 8) + int'(sgn);
    pulseStart(wide, sgn);
    lat = 0;
    while (!trackEn && lat < 20) begin @(negedge clk); lat++; end
    chk(lat >= 1 && lat <= 2, "R2 start latency", lat, 2);
    hi = 0;
    while (trackEn && hi < 50) begin hi++; @(negedge clk); end
    chk(hi == 6, "R2 track length", hi, 6);
    conv = 0; sawTop = 1'b0;
    while (!done && conv < 100) begin
      @(negedge clk); conv++;
      if (dacWord[10]) sawTop = 1'b1;
    end
    chk(conv == 2 * n, "R3 conversion clocks", conv, 2 * n);
    chk(int'(result) == expCode(wide, sgn, x), sgn ? "R7 R8 signed code" : "R6 R8 unsigned code",
        int'(result), expCode(wide, sgn, x));
    if (!sgn) chk(!sawTop, "R6 sign switch stays open", int'(sawTop), 0);
    @(negedge clk);
    chk(done == 0, "R4 done one clock", int'(done), 0);
    repeat (3) @(negedge clk);
    chk(int'(result) == expCode(wide, sgn, x), "R10 result held", int'(result), expCode(wide, sgn, x));
  endtask

  // R5 one-step and trial order check in signed 10-bit mode
  task automatic testTrialOrder();
    tbSigned = 1'b1; vin = 5;
    pulseStart(1'b1, 1'b1);
    while (!trackEn) @(negedge clk);
    while (trackEn) @(negedge clk);
    // first decision period: only the sign/offset trial bit is set
    chk(dacWord == 11'h400, "R5 first trial word", int'(dacWord), 'h400);
    repeat (2) @(negedge clk);
    // sign kept (input >= 0), next trial bit 9 set
    chk(dacWord == 11'h600, "R5 second trial word", int'(dacWord), 'h600);
    while (!done) @(negedge clk);
    chk(result == 11'd5, "R5 final code", int'(result), 5);
  endtask

  // R9
  task automatic testQueued();
    int gap;
    tbSigned = 1'b0; vin = 700;
    pulseStart(1'b1, 1'b0);
    while (!trackEn) @(negedge clk);
    while (trackEn) @(negedge clk);
    pulseStart(1'b0, 1'b0);
    while (!done) @(negedge clk);
    chk(result == 11'd700, "R9 running result unaffected", int'(result), 700);
    gap = 0;
    while (!trackEn && gap < 10) begin @(negedge clk); gap++; end
    chk(gap >= 1 && gap <= 3, "R9 queued launch", gap, 2);
    while (!done) @(negedge clk);
    chk(result == 11'd175, "R9 queued config used", int'(result), 175);
  endtask

  // R1 reset in mid-conversion
  task automatic testMidReset();
    tbSigned = 1'b0; vin = 300;
    pulseStart(1'b1, 1'b0);
    repeat (12) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk(trackEn == 0 && done == 0, "R1 mid reset control", int'({trackEn, done}), 0);
    chk(result == 0 && dacWord == 0, "R1 mid reset data", int'(result | dacWord), 0);
    rstN = 1'b1;
    repeat (30) @(negedge clk);
    chk(done == 0 && trackEn == 0, "R1 no pending after reset", int'({done, trackEn}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    testReset();
    runOne(1'b0, 1'b0, 512);
    runOne(1'b1, 1'b0, 700);
    runOne(1'b1, 1'b0, -50);
    runOne(1'b0, 1'b0, -3);
    runOne(1'b1, 1'b1, 1023);
    runOne(1'b1, 1'b1, 1);
    runOne(1'b1, 1'b1, -1);
    runOne(1'b1, 1'b1, -1024);
    runOne(1'b0, 1'b1, -9);
    runOne(1'b0, 1'b1, 1023);
    runOne(1'b0, 1'b0, 1023);
    testTrialOrder();
    testQueued();
    testMidReset();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule